// File: doc/BRIEF.md
# Audio Sample Routing Crossbar

This block moves audio samples between five receivers, three transmit channels and a processor, over one shared 40-bit sample bus. Each receiver presents a sample together with a one-cycle valid strobe. The processor writes samples through three output ports. These ports share a single write bus, so only one port is written in a given cycle. Each of the three transmit channels has its own source selector. A selector may point at any receiver or at any processor output port. A processor write therefore lands in every transmit channel that currently selects that port.

The processor also has three read channels. Each read channel selects one of the five receivers and buffers its samples. The processor drains a read channel by popping its head. Every channel, transmit or read, has an 8-entry elastic FIFO behind its selector. This FIFO absorbs the timing offset between the source that produces samples and the side that consumes them.

Each FIFO exposes a level-based request flag, a sticky overflow flag and a sticky underflow flag, so software can poll when to write or read. Changing a channel's selector flushes that channel, so samples from an old source never mix with samples from a new one. Each FIFO is controlled by a small state machine with three states:
- EMPTY to FILL on an accepted push.
- FILL to FULL when the count reaches the depth.
- FILL to EMPTY when the count reaches zero.
- FULL to FILL on a pop that has no accepted push in the same cycle.
- Any state to EMPTY on a flush.

Top module: `audio_xbar`

## Requirements
- R1: Selector codes are 0 to 2 for the three serial receivers, 3 to 4 for the two IEC958 receivers and 5 to 7 for processor ports 1 to 3. Codes 8 to 15 select nothing, and 15 is the idle value. A channel that selects receiver n, where n is the code, pushes `rx_data[n*40 +: 40]` in every cycle in which `rx_valid[n]` is high.
- R2: A processor write (`pw_we`, with `pw_idx` 0 to 2 naming ports 1 to 3; `pw_idx` 3 writes nothing) pushes `pw_data` into every transmit channel whose selector equals 5 + `pw_idx`, in the same cycle.
- R3: Read channels accept receiver codes only. Codes 5 to 7 on a read channel behave as no source, so processor writes never reach a read channel.
- R4: Each channel holds up to 8 samples in arrival order. Its data output shows the oldest sample, and a pop advances to the next sample at the following clock edge.
- R5: A push into a full FIFO without a pop in the same cycle is dropped and sets that channel's sticky overflow flag. A push together with a pop on a full FIFO is accepted.
- R6: A pop from an empty FIFO changes nothing except setting the sticky underflow flag. While a channel is empty, its data output reads zero. A push in that same cycle is still accepted.
- R7: A transmit request flag is high while the channel holds 4 or fewer samples.
- R8: A read request flag is high while the channel holds at least one sample.
- R9: In any cycle where a channel's selector differs from its value at the previous clock edge (15 right after reset), the channel empties and clears its overflow and underflow flags at the next edge. Any push or pop in that cycle is ignored.
- R10: During and after reset, all FIFOs are empty, all data outputs are zero, the transmit request flags are high, and the read request flags, overflow flags and underflow flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 5 | Per-receiver sample strobe |
| rx_data | input | 200 | Receiver samples, 40 bits each, receiver n at bits n*40 |
| pw_we | input | 1 | Processor write strobe |
| pw_idx | input | 2 | Processor output port written (0 to 2) |
| pw_data | input | 40 | Processor write sample |
| tx_sel | input | 12 | Transmit channel selectors, 4 bits each |
| tx_pop | input | 3 | Transmit channel pop |
| tx_data | output | 120 | Transmit channel head samples |
| tx_req | output | 3 | Transmit half-empty request |
| tx_ovf | output | 3 | Transmit sticky overflow |
| tx_unf | output | 3 | Transmit sticky underflow |
| pr_sel | input | 12 | Read channel selectors, 4 bits each |
| pr_pop | input | 3 | Read channel pop |
| pr_data | output | 120 | Read channel head samples |
| pr_req | output | 3 | Read not-empty request |
| pr_ovf | output | 3 | Read sticky overflow |
| pr_unf | output | 3 | Read sticky underflow |

## Verification
The bench builds the block with its defaults: 40-bit samples, a depth of 8, and three transmit and three read channels. The shallow depth lets a few cycles of heavy pushing reach FULL and drop samples. The half mark of 4 is crossed many times during each drain phase. With three channels per side, a test can point two or three transmit channels at one processor port to exercise fan-out. The same test can point read channels at processor codes to show that those writes are ignored.

// File: rtl/xb_pkg.sv
package xb_pkg;
    localparam int SEL_W       = 4;
    localparam int N_RX        = 5;
    localparam int N_PW        = 3;
    localparam int PW_BASE     = 5;
    localparam logic [SEL_W-1:0] SEL_IDLE = 4'd15;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_FILL  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_e;
endpackage

// File: rtl/xb_src_mux.sv
module xb_src_mux
    import xb_pkg::*;
#(
    parameter int DW       = 40,
    parameter bit ALLOW_PW = 1'b1
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_RX-1:0]    rx_valid,
    input  logic [N_RX*DW-1:0] rx_data,
    input  logic               pw_we,
    input  logic [1:0]         pw_idx,
    input  logic [DW-1:0]      pw_data,
    output logic               push,
    output logic [DW-1:0]      din
);
    logic          rx_hit;
    logic [DW-1:0] rx_word;
    logic          pw_hit;

    always_comb begin
        rx_hit  = 1'b0;
        rx_word = '0;
        for (int r = 0; r < N_RX; r++) begin
            if (sel == SEL_W'(r)) begin
                rx_hit  = rx_valid[r];
                rx_word = rx_data[r*DW +: DW];
            end
        end
    end

    generate
        if (ALLOW_PW) begin : g_pw
            always_comb begin
                pw_hit = 1'b0;
                for (int p = 0; p < N_PW; p++) begin
                    if (sel == SEL_W'(PW_BASE + p) && pw_we && pw_idx == 2'(p))
                        pw_hit = 1'b1;
                end
            end
        end else begin : g_no_pw
            logic unused_pw;
            assign unused_pw = ^{pw_we, pw_idx, pw_data};
            assign pw_hit    = 1'b0;
        end
    endgenerate

    assign push = rx_hit | pw_hit;
    assign din  = pw_hit ? pw_data : rx_word;
endmodule

// File: rtl/xb_fifo.sv
module xb_fifo
    import xb_pkg::*;
#(
    parameter int DW    = 40,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DW-1:0]              din,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ovf,
    output logic                       unf
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    fifo_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [PTR_W-1:0] wr_q, rd_q;
    logic             ovf_q, unf_q, ovf_d, unf_d;
    logic             do_push, do_pop;
    logic [DW-1:0]    mem_q [DEPTH];

    always_comb begin
        do_pop  = pop  && !flush && (state_q != FS_EMPTY);
        do_push = push && !flush && ((state_q != FS_FULL) || pop);
        cnt_d   = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        ovf_d   = flush ? 1'b0 : (ovf_q | (push && !do_push));
        unf_d   = flush ? 1'b0 : (unf_q | (pop && (state_q == FS_EMPTY)));
        state_d = state_q;
        if (flush) begin
            state_d = FS_EMPTY;
        end else begin
            unique case (state_q)
                FS_EMPTY: if (do_push) state_d = (cnt_d == CNT_W'(DEPTH)) ? FS_FULL : FS_FILL;
                FS_FILL: begin
                    if (cnt_d == '0)                 state_d = FS_EMPTY;
                    else if (cnt_d == CNT_W'(DEPTH)) state_d = FS_FULL;
                end
                FS_FULL:  if (do_pop && !do_push) state_d = FS_FILL;
                default:  state_d = FS_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_EMPTY;
            cnt_q   <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= flush ? '0 : cnt_d;
            wr_q    <= flush ? '0 : (do_push ? wr_q + 1'b1 : wr_q);
            rd_q    <= flush ? '0 : (do_pop  ? rd_q + 1'b1 : rd_q);
            ovf_q   <= ovf_d;
            unf_q   <= unf_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= din;
    end

    always_comb begin
        dout  = (state_q == FS_EMPTY) ? '0 : mem_q[rd_q];
        level = cnt_q;
        ovf   = ovf_q;
        unf   = unf_q;
    end
endmodule

// File: rtl/xb_channel.sv
module xb_channel
    import xb_pkg::*;
#(
    parameter int DW    = 40,
    parameter int DEPTH = 8,
    parameter bit IS_TX = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_RX-1:0]    rx_valid,
    input  logic [N_RX*DW-1:0] rx_data,
    input  logic               pw_we,
    input  logic [1:0]         pw_idx,
    input  logic [DW-1:0]      pw_data,
    input  logic               pop,
    output logic [DW-1:0]      dout,
    output logic               req,
    output logic               ovf,
    output logic               unf
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [SEL_W-1:0] sel_q;
    logic             flush, push;
    logic [DW-1:0]    din;
    logic [CNT_W-1:0] level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_IDLE;
        else        sel_q <= sel;
    end
    assign flush = (sel != sel_q);

    xb_src_mux #(.DW(DW), .ALLOW_PW(IS_TX)) u_mux (
        .sel(sel), .rx_valid(rx_valid), .rx_data(rx_data),
        .pw_we(pw_we), .pw_idx(pw_idx), .pw_data(pw_data),
        .push(push), .din(din)
    );

    xb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
        .din(din), .dout(dout), .level(level), .ovf(ovf), .unf(unf)
    );

    generate
        if (IS_TX) begin : g_half
            assign req = (level <= CNT_W'(DEPTH/2));
        end else begin : g_any
            assign req = (level != '0);
        end
    endgenerate
endmodule

// File: rtl/audio_xbar.sv
module audio_xbar
    import xb_pkg::*;
#(
    parameter int DW    = 40,
    parameter int DEPTH = 8,
    parameter int N_TX  = 3,
    parameter int N_PR  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_RX-1:0]       rx_valid,
    input  logic [N_RX*DW-1:0]    rx_data,
    input  logic                  pw_we,
    input  logic [1:0]            pw_idx,
    input  logic [DW-1:0]         pw_data,
    input  logic [N_TX*SEL_W-1:0] tx_sel,
    input  logic [N_TX-1:0]       tx_pop,
    output logic [N_TX*DW-1:0]    tx_data,
    output logic [N_TX-1:0]       tx_req,
    output logic [N_TX-1:0]       tx_ovf,
    output logic [N_TX-1:0]       tx_unf,
    input  logic [N_PR*SEL_W-1:0] pr_sel,
    input  logic [N_PR-1:0]       pr_pop,
    output logic [N_PR*DW-1:0]    pr_data,
    output logic [N_PR-1:0]       pr_req,
    output logic [N_PR-1:0]       pr_ovf,
    output logic [N_PR-1:0]       pr_unf
);
    generate
        for (genvar c = 0; c < N_TX; c++) begin : g_tx
            xb_channel #(.DW(DW), .DEPTH(DEPTH), .IS_TX(1'b1)) u_ch (
                .clk(clk), .rst_n(rst_n), .sel(tx_sel[c*SEL_W +: SEL_W]),
                .rx_valid(rx_valid), .rx_data(rx_data),
                .pw_we(pw_we), .pw_idx(pw_idx), .pw_data(pw_data),
                .pop(tx_pop[c]), .dout(tx_data[c*DW +: DW]),
                .req(tx_req[c]), .ovf(tx_ovf[c]), .unf(tx_unf[c])
            );
        end
        for (genvar c = 0; c < N_PR; c++) begin : g_pr
            xb_channel #(.DW(DW), .DEPTH(DEPTH), .IS_TX(1'b0)) u_ch (
                .clk(clk), .rst_n(rst_n), .sel(pr_sel[c*SEL_W +: SEL_W]),
                .rx_valid(rx_valid), .rx_data(rx_data),
                .pw_we(pw_we), .pw_idx(pw_idx), .pw_data(pw_data),
                .pop(pr_pop[c]), .dout(pr_data[c*DW +: DW]),
                .req(pr_req[c]), .ovf(pr_ovf[c]), .unf(pr_unf[c])
            );
        end
    endgenerate
endmodule

// File: rtl/xb_checker.sv
module xb_checker
    import xb_pkg::*;
#(
    parameter int DW    = 40,
    parameter int N_TX  = 3,
    parameter int N_PR  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_RX-1:0]       rx_valid,
    input logic [N_TX*SEL_W-1:0] tx_sel,
    input logic [N_TX-1:0]       tx_req,
    input logic [N_TX-1:0]       tx_ovf,
    input logic [N_TX-1:0]       tx_unf,
    input logic [N_PR*SEL_W-1:0] pr_sel,
    input logic [N_PR*DW-1:0]    pr_data,
    input logic [N_PR-1:0]       pr_req,
    input logic [N_PR-1:0]       pr_ovf
);
    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    generate
        for (genvar c = 0; c < N_TX; c++) begin : g_tx
            AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                started && (tx_sel[c*SEL_W +: SEL_W] != $past(tx_sel[c*SEL_W +: SEL_W]))
                |=> tx_req[c] && !tx_ovf[c] && !tx_unf[c]); // R9
            AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                started && tx_unf[c] && $stable(tx_sel[c*SEL_W +: SEL_W])
                |=> tx_unf[c]); // R6
        end
        for (genvar c = 0; c < N_PR; c++) begin : g_pr
            AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !pr_req[c] |-> (pr_data[c*DW +: DW] == '0)); // R6
            AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                started && pr_ovf[c] && $stable(pr_sel[c*SEL_W +: SEL_W])
                |=> pr_ovf[c]); // R5
            AST_RX_FILLS_READ: assert property (@(posedge clk) disable iff (!rst_n)
                started && (pr_sel[c*SEL_W +: SEL_W] == 4'd0)
                && $stable(pr_sel[c*SEL_W +: SEL_W]) && rx_valid[0]
                |=> pr_req[c]); // R8
            AST_READ_IGNORES_PW: assert property (@(posedge clk) disable iff (!rst_n)
                started && (pr_sel[c*SEL_W +: SEL_W] >= 4'd5)
                && (pr_sel[c*SEL_W +: SEL_W] <= 4'd7)
                && $stable(pr_sel[c*SEL_W +: SEL_W]) && !pr_req[c]
                |=> !pr_req[c]); // R3
        end
    endgenerate
endmodule

bind audio_xbar xb_checker #(.DW(DW), .N_TX(N_TX), .N_PR(N_PR)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
    .tx_sel(tx_sel), .tx_req(tx_req), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
    .pr_sel(pr_sel), .pr_data(pr_data), .pr_req(pr_req), .pr_ovf(pr_ovf)
);

// File: tb/audio_xbar_test.sv
module audio_xbar_test;
    localparam int DW = 40;
    localparam int DEPTH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [4:0]     rx_valid = '0;
    logic [5*DW-1:0] rx_data = '0;
    logic           pw_we = 1'b0;
    logic [1:0]     pw_idx = '0;
    logic [DW-1:0]  pw_data = '0;
    logic [11:0]    tx_sel = 12'hFFF;
    logic [2:0]     tx_pop = '0;
    logic [3*DW-1:0] tx_data;
    logic [2:0]     tx_req, tx_ovf, tx_unf;
    logic [11:0]    pr_sel = 12'hFFF;
    logic [2:0]     pr_pop = '0;
    logic [3*DW-1:0] pr_data;
    logic [2:0]     pr_req, pr_ovf, pr_unf;

    audio_xbar uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .pw_we(pw_we), .pw_idx(pw_idx), .pw_data(pw_data),
        .tx_sel(tx_sel), .tx_pop(tx_pop), .tx_data(tx_data),
        .tx_req(tx_req), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
        .pr_sel(pr_sel), .pr_pop(pr_pop), .pr_data(pr_data),
        .pr_req(pr_req), .pr_ovf(pr_ovf), .pr_unf(pr_unf)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    logic [DW-1:0] txq [3][$];
    logic [DW-1:0] prq [3][$];
    int  t_prev [3], p_prev [3], tsel [3], psel [3];
    bit  t_ovf [3], t_unf [3], p_ovf [3], p_unf [3];
    int  p_rx, p_pw, p_tpop, p_ppop, p_chg;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        for (int c = 0; c < 3; c++) begin
            // R1 R2 R4 R9: head of each transmit channel
            chk("R1 R2 R4 R9 tx data", tx_data[c*DW +: DW], txq[c].size() > 0 ? txq[c][0] : '0);
            chk("R7 tx req", DW'(tx_req[c]), DW'(txq[c].size() <= DEPTH/2));
            chk("R5 tx ovf", DW'(tx_ovf[c]), DW'(t_ovf[c]));
            chk("R6 tx unf", DW'(tx_unf[c]), DW'(t_unf[c]));
            // R3 R4 R9: head of each read channel
            chk("R3 R4 R9 pr data", pr_data[c*DW +: DW], prq[c].size() > 0 ? prq[c][0] : '0);
            chk("R8 pr req", DW'(pr_req[c]), DW'(prq[c].size() > 0));
            chk("R5 pr ovf", DW'(pr_ovf[c]), DW'(p_ovf[c]));
            chk("R6 pr unf", DW'(pr_unf[c]), DW'(p_unf[c]));
        end
    endtask

    function automatic int pick_sel();
        int v = int'($urandom_range(10));
        if (v == 8) return 15;
        if (v == 9) return 9;
        if (v == 10) return 12;
        return v;
    endfunction

    task automatic drive();
        for (int r = 0; r < 5; r++) begin
            rx_valid[r] = ($urandom_range(99) < p_rx);
            rx_data[r*DW +: DW] = DW'({$urandom(), $urandom()});
        end
        pw_we   = ($urandom_range(99) < p_pw);
        pw_idx  = 2'($urandom_range(3));
        pw_data = DW'({$urandom(), $urandom()});
        if ($urandom_range(99) < p_chg) tsel[$urandom_range(2)] = pick_sel();
        if ($urandom_range(99) < p_chg) psel[$urandom_range(2)] = pick_sel();
        for (int c = 0; c < 3; c++) begin
            tx_sel[c*4 +: 4] = 4'(tsel[c]);
            pr_sel[c*4 +: 4] = 4'(psel[c]);
            tx_pop[c] = ($urandom_range(99) < p_tpop);
            pr_pop[c] = ($urandom_range(99) < p_ppop);
        end
    endtask

    task automatic step_one(inout logic [DW-1:0] q[$], inout int prev, input int s,
                            input bit is_tx, input bit pop, inout bit ovf, inout bit unf);
        bit push = 1'b0;
        logic [DW-1:0] val = '0;
        int sz;
        if (s != prev) begin
            prev = s;
            q.delete();
            ovf = 1'b0;
            unf = 1'b0;
            return;
        end
        if (s < 5) begin
            push = rx_valid[s];
            val  = rx_data[s*DW +: DW];
        end else if (is_tx && s <= 7 && pw_we && int'(pw_idx) == s - 5) begin
            push = 1'b1;
            val  = pw_data;
        end
        sz = q.size();
        if (pop) begin
            if (sz > 0) void'(q.pop_front());
            else        unf = 1'b1;
        end
        if (push) begin
            if (sz < DEPTH || pop) q.push_back(val);
            else                   ovf = 1'b1;
        end
    endtask

    task automatic step_model();
        for (int c = 0; c < 3; c++) begin
            step_one(txq[c], t_prev[c], tsel[c], 1'b1, tx_pop[c], t_ovf[c], t_unf[c]);
            step_one(prq[c], p_prev[c], psel[c], 1'b0, pr_pop[c], p_ovf[c], p_unf[c]);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            drive();
            step_model();
        end
    endtask

    initial begin
        for (int c = 0; c < 3; c++) begin
            t_prev[c] = 15; p_prev[c] = 15; tsel[c] = 15; psel[c] = 15;
            t_ovf[c] = 0; t_unf[c] = 0; p_ovf[c] = 0; p_unf[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 tx data", tx_data[DW-1:0], '0);
        chk("R10 tx req", DW'(tx_req), DW'(3'b111));
        chk("R10 pr req", DW'(pr_req), '0);
        chk("R10 flags", DW'({tx_ovf, tx_unf, pr_ovf, pr_unf}), '0);
        rst_n = 1'b1;

        // fill with fan-out of port 1 into two transmit channels (R2, R5)
        tsel = '{5, 5, 0}; psel = '{0, 3, 6};
        p_rx = 60; p_pw = 70; p_tpop = 5; p_ppop = 5; p_chg = 0;
        run(200);
        // drain past empty (R6, R7, R8)
        p_rx = 10; p_pw = 10; p_tpop = 90; p_ppop = 90;
        run(200);
        // all transmit channels on port 2, read channels on receivers (R1, R2, R3)
        tsel = '{6, 6, 6}; psel = '{1, 2, 4};
        p_rx = 50; p_pw = 50; p_tpop = 40; p_ppop = 40;
        run(200);
        // read channels pointed at processor codes must stay empty (R3)
        psel = '{5, 6, 7};
        p_pw = 90;
        run(100);
        // random selector changes and flushes (R9)
        p_rx = 40; p_pw = 40; p_tpop = 40; p_ppop = 40; p_chg = 4;
        run(3000);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule